// File: doc/BRIEF.md
# Management Sideband Reset-Effects Controller

This block sits between a device's reset and power-state logic and the byte-level slave that serves a management controller over SMBus. It watches six reset sources and applies a per-source effect to that sideband. The sources are a hard reset, an alternate reset, an isolate input, a return from power state D3 to D0, a software reset pulse and a selective reset pulse. Hard-class sources (alternate reset, isolate, hard reset) cut off the transaction in flight at once through a one-cycle kill strobe to the SMBus engine. They also drop the status-enable and receive-enable flags.

Graceful sources (D3-to-D0, software reset, selective reset) work differently. They let the cycle in flight run on to its STOP, but every read in the rest of that cycle returns zero and every write in it is dropped. They then announce re-initialization by pulling the alert output low and setting an init bit in the status word. The alert is released when the management controller reads that status word in a normal cycle. Only D3-to-D0 also clears the two flags.

The register file seen over the sideband holds three registers. The status word at address 0 has bit 0 = init, bit 1 = status-enable and bit 2 = receive-enable; the other bits read as 0. The control register at address 1 reads and writes the two flags at bits 1 and 2. A scratch register at address 2 is DW bits wide. Any other address reads as 0 and ignores writes.

Top module: `mgmt_reset_fx`

## Requirements
- R1: After the block's power-on reset, alertN is 1, busKill is 0, and reads of addresses 0, 1 and 2 return 0.
- R2: In a normal cycle, a write to address 1 sets the flags from data bits 1 and 2. A write to address 2 stores the byte. Each read returns the register's value on rdData with rdValid high in the cycle after rdReq. Address 0 reports the flags at bits 1 and 2.
- R3: The first two hard-class sources behave as follows. An alternate-reset assertion (falling edge of altRstN) raises busKill for exactly one cycle, and so does a hard-reset assertion outside D3. Each clears both flags. A later release of either input produces no kill.
- R4: The isolate input acts only on its deasserting (rising) edge, with a one-cycle kill and both flags cleared. Its asserting edge has no effect.
- R5: While the power state is D3 (pwrState = 3), hard reset produces no kill on its asserting edge. It produces a one-cycle kill on its deasserting edge.
- R6: A D3-to-D0 transition (pwrState goes from 3 to 0) during a transaction has these effects until busStop: every read returns 0 and every write leaves all registers unchanged. The next transaction runs normally.
- R7: A D3-to-D0 transition drives alertN low, sets status bit 0 and clears both flags.
- R8: A software reset or selective reset pulse aborts the open cycle in the same way as R6 and sets alert and init as in R7. Both flags keep their values.
- R9: A read of address 0 in a normal cycle returns the init bit and then clears it, so alertN returns to 1. The same read inside an aborted cycle clears nothing.
- R10: If a hard-class event and a graceful event fall in the same clock, the hard effects win. There is a kill and the flags are cleared. Alert and init are not set, and no abort is latched.
- R11: A graceful event while no transaction is open sets alert and init but does not abort the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Block power-on reset, asynchronous, active low |
| hardRstN | input | 1 | Hard reset, asynchronous, active low |
| altRstN | input | 1 | Alternate reset, asynchronous, active low |
| isolateN | input | 1 | Isolate, asynchronous, active low, acts on release |
| pwrState | input | 2 | Current power state, 0 = D0, 3 = D3 |
| swRst | input | 1 | Software reset pulse, one cycle |
| selRst | input | 1 | Selective reset pulse, one cycle |
| busStart | input | 1 | SMBus START seen, transaction opens |
| busStop | input | 1 | SMBus STOP seen, transaction closes |
| rdReq | input | 1 | Byte read request from the slave engine |
| wrReq | input | 1 | Byte write request from the slave engine |
| regAddr | input | AW | Register address of the request |
| wrData | input | DW | Write byte |
| rdValid | output | 1 | Read data valid, one cycle after rdReq |
| rdData | output | DW | Read byte |
| busKill | output | 1 | One-cycle strobe that ends the SMBus transaction at once |
| alertN | output | 1 | Active-low alert to the management controller |

## Verification
The main function is exercised with one pattern for each source class.
- The software-reset pattern and the D3-to-D0 pattern are each launched inside an open transaction. Comparing them separates flag preservation from flag clearing, while both show zeroed reads and dropped writes.
- A selective reset with the bus idle separates an abort that is tied to the open cycle from one that would wrongly outlive it.
- The asynchronous sources are toggled in both directions, inside and outside D3. Counting kill pulses tells the asserting-edge sources apart from the releasing-edge ones.
- A hard event placed in the same clock as a software reset shows which effects take precedence.

// File: rtl/mgmt_reset_fx_pkg.sv
package mgmt_reset_fx_pkg;

  // Strobes from the control module to the datapath, valid in the cycle an event fires.
  typedef struct packed {
    logic killNow;      // hard-class event: end transaction at once
    logic clearFlags;   // drop status-enable and receive-enable
    logic setInit;      // graceful event: raise init bit and alert
    logic blockAccess;  // reads give zero, writes dropped
  } fxStrobe_t;

  // Status word bit positions, decoded by the management controller.
  localparam int INIT_BIT   = 0;
  localparam int STATEN_BIT = 1;
  localparam int RXEN_BIT   = 2;

  localparam logic [1:0] PWR_D0 = 2'b00;
  localparam logic [1:0] PWR_D3 = 2'b11;

endpackage

// File: rtl/mgmt_reset_sync_edge.sv
module mgmt_reset_sync_edge #(
  parameter int W           = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         porN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] riseEv,
  output logic [W-1:0] fallEv,
  output logic [W-1:0] levelOut
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevQ;

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        chain <= '1;   // inputs are active low, idle high
        prevQ <= 1'b1;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], asyncIn[i]};
        prevQ <= chain[LAST];
      end
    end

    assign riseEv[i]   =  chain[LAST] & ~prevQ;
    assign fallEv[i]   = ~chain[LAST] &  prevQ;
    assign levelOut[i] =  chain[LAST];
  end

endmodule

// File: rtl/mgmt_reset_fx_ctrl.sv
module mgmt_reset_fx_ctrl
  import mgmt_reset_fx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       hardRstN,
  input  logic       altRstN,
  input  logic       isolateN,
  input  logic [1:0] pwrState,
  input  logic       swRst,
  input  logic       selRst,
  input  logic       busStart,
  input  logic       busStop,
  output fxStrobe_t  stb,
  output logic       busKill
);
  localparam int NSRC   = 3;
  localparam int IX_HRD = 0;
  localparam int IX_ALT = 1;
  localparam int IX_ISO = 2;

  logic [NSRC-1:0] riseEv, fallEv, levelSync;
  logic [1:0]      pwrQ;
  logic            busyQ, abortQ, killQ;
  logic            inD3, d3Ev, softEv, hardEv, graceEv;

  mgmt_reset_sync_edge #(.W(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .porN     (porN),
    .asyncIn  ({isolateN, altRstN, hardRstN}),
    .riseEv   (riseEv),
    .fallEv   (fallEv),
    .levelOut (levelSync)
  );

  assign inD3   = (pwrQ == PWR_D3);
  assign d3Ev   = (pwrQ == PWR_D3) && (pwrState == PWR_D0);
  assign softEv = swRst | selRst;

  // Hard reset acts on assertion normally, on release while in D3.
  assign hardEv = fallEv[IX_ALT]
                | riseEv[IX_ISO]
                | (inD3 ? riseEv[IX_HRD] : fallEv[IX_HRD]);

  // Hard-class effects take priority over graceful ones in the same clock.
  assign graceEv = (d3Ev | softEv) & ~hardEv;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pwrQ   <= PWR_D0;
      busyQ  <= 1'b0;
      abortQ <= 1'b0;
      killQ  <= 1'b0;
    end else begin
      pwrQ  <= pwrState;
      killQ <= hardEv;
      if (hardEv) begin
        busyQ  <= 1'b0;
        abortQ <= 1'b0;
      end else if (busStop) begin
        busyQ  <= 1'b0;
        abortQ <= 1'b0;
      end else begin
        if (busStart) busyQ <= 1'b1;
        if (graceEv && (busyQ || busStart)) abortQ <= 1'b1;
      end
    end
  end

  always_comb begin
    stb             = '0;
    stb.killNow     = hardEv;
    stb.clearFlags  = hardEv | (d3Ev & ~hardEv);
    stb.setInit     = graceEv;
    stb.blockAccess = hardEv | abortQ | (graceEv & busyQ);
  end

  assign busKill = killQ;

  // Synchronized levels are only consumed through the edge strobes.
  logic unusedLevels;
  assign unusedLevels = ^levelSync;

endmodule

// File: rtl/mgmt_reset_fx_dp.sv
module mgmt_reset_fx_dp
  import mgmt_reset_fx_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          porN,
  input  fxStrobe_t     stb,
  input  logic          rdReq,
  input  logic          wrReq,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] wrData,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          alertN
);
  localparam logic [AW-1:0] ADDR_STATUS  = AW'(0);
  localparam logic [AW-1:0] ADDR_CTRL    = AW'(1);
  localparam logic [AW-1:0] ADDR_SCRATCH = AW'(2);

  logic          statEnQ, rxEnQ, initQ;
  logic [DW-1:0] scratchQ;
  logic [DW-1:0] statusWord, ctrlWord, readMux;
  logic          wrOk, rdOk, statusRead;

  always_comb begin
    statusWord             = '0;
    statusWord[INIT_BIT]   = initQ;
    statusWord[STATEN_BIT] = statEnQ;
    statusWord[RXEN_BIT]   = rxEnQ;
    ctrlWord               = '0;
    ctrlWord[STATEN_BIT]   = statEnQ;
    ctrlWord[RXEN_BIT]     = rxEnQ;
    unique case (regAddr)
      ADDR_STATUS:  readMux = statusWord;
      ADDR_CTRL:    readMux = ctrlWord;
      ADDR_SCRATCH: readMux = scratchQ;
      default:      readMux = '0;
    endcase
  end

  assign wrOk       = wrReq & ~stb.blockAccess;
  assign rdOk       = rdReq & ~stb.blockAccess;
  assign statusRead = rdOk & (regAddr == ADDR_STATUS);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      statEnQ  <= 1'b0;
      rxEnQ    <= 1'b0;
      initQ    <= 1'b0;
      scratchQ <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      rdValid <= rdReq;
      if (rdReq) rdData <= rdOk ? readMux : '0;

      if (stb.clearFlags) begin
        statEnQ <= 1'b0;
        rxEnQ   <= 1'b0;
      end else if (wrOk && regAddr == ADDR_CTRL) begin
        statEnQ <= wrData[STATEN_BIT];
        rxEnQ   <= wrData[RXEN_BIT];
      end

      if (wrOk && regAddr == ADDR_SCRATCH) scratchQ <= wrData;

      if (stb.setInit)     initQ <= 1'b1;
      else if (statusRead) initQ <= 1'b0;
    end
  end

  assign alertN = ~initQ;

endmodule

// File: rtl/mgmt_reset_fx.sv
module mgmt_reset_fx
  import mgmt_reset_fx_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          porN,
  input  logic          hardRstN,
  input  logic          altRstN,
  input  logic          isolateN,
  input  logic [1:0]    pwrState,
  input  logic          swRst,
  input  logic          selRst,
  input  logic          busStart,
  input  logic          busStop,
  input  logic          rdReq,
  input  logic          wrReq,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] wrData,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          busKill,
  output logic          alertN
);
  fxStrobe_t stb;

  mgmt_reset_fx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .hardRstN (hardRstN),
    .altRstN  (altRstN),
    .isolateN (isolateN),
    .pwrState (pwrState),
    .swRst    (swRst),
    .selRst   (selRst),
    .busStart (busStart),
    .busStop  (busStop),
    .stb      (stb),
    .busKill  (busKill)
  );

  mgmt_reset_fx_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk     (clk),
    .porN    (porN),
    .stb     (stb),
    .rdReq   (rdReq),
    .wrReq   (wrReq),
    .regAddr (regAddr),
    .wrData  (wrData),
    .rdValid (rdValid),
    .rdData  (rdData),
    .alertN  (alertN)
  );

endmodule

// File: rtl/mgmt_reset_fx_chk.sv
module mgmt_reset_fx_chk
  import mgmt_reset_fx_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          porN,
  input fxStrobe_t     stb,
  input logic          rdValid,
  input logic [DW-1:0] rdData,
  input logic          busKill,
  input logic          alertN
);
  AST_ABORT_READ_ZERO: assert property (@(posedge clk) disable iff (!porN)
    (rdValid && $past(stb.blockAccess)) |-> (rdData == '0)); // R6

  AST_GRACE_RAISES_ALERT: assert property (@(posedge clk) disable iff (!porN)
    $past(stb.setInit) |-> !alertN); // R7

  AST_KILL_KEEPS_ALERT: assert property (@(posedge clk) disable iff (!porN)
    busKill |-> $stable(alertN)); // R10

  AST_ALERT_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (!porN)
    $rose(alertN) |-> (rdValid && rdData[INIT_BIT])); // R9

endmodule

bind mgmt_reset_fx mgmt_reset_fx_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .porN    (porN),
  .stb     (stb),
  .rdValid (rdValid),
  .rdData  (rdData),
  .busKill (busKill),
  .alertN  (alertN)
);

// File: tb/mgmt_reset_fx_bench.sv
module mgmt_reset_fx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          porN, hardRstN, altRstN, isolateN, swRst, selRst;
  logic          busStart, busStop, rdReq, wrReq;
  logic [1:0]    pwrState;
  logic [AW-1:0] regAddr;
  logic [DW-1:0] wrData;
  logic          rdValid, busKill, alertN;
  logic [DW-1:0] rdData;

  int errCnt = 0;
  int chkCnt = 0;
  int killCnt = 0;
  logic [DW-1:0] expQ[$];
  string         tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_reset_fx #(.AW(AW), .DW(DW)) u_mgmt_reset_fx (
    .clk(clk), .porN(porN), .hardRstN(hardRstN), .altRstN(altRstN),
    .isolateN(isolateN), .pwrState(pwrState), .swRst(swRst), .selRst(selRst),
    .busStart(busStart), .busStop(busStop), .rdReq(rdReq), .wrReq(wrReq),
    .regAddr(regAddr), .wrData(wrData), .rdValid(rdValid), .rdData(rdData),
    .busKill(busKill), .alertN(alertN)
  );

  always @(posedge clk) if (porN && busKill) killCnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected byte for every read response.
  always @(negedge clk) begin
    if (porN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected read response", int'(rdData), 0);
      end else begin
        automatic logic [DW-1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(rdData == e, t, int'(rdData), int'(e));
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic txStart();
    busStart = 1'b1; @(negedge clk); busStart = 1'b0;
  endtask

  task automatic txStop();
    busStop = 1'b1; @(negedge clk); busStop = 1'b0; @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    regAddr = AW'(a); wrData = DW'(d); wrReq = 1'b1;
    @(negedge clk); wrReq = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input string tag);
    expQ.push_back(DW'(e)); tagQ.push_back(tag);
    regAddr = AW'(a); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    porN = 0; hardRstN = 1; altRstN = 1; isolateN = 1; swRst = 0; selRst = 0;
    busStart = 0; busStop = 0; rdReq = 0; wrReq = 0; pwrState = 2'd0;
    regAddr = '0; wrData = '0;
    idle(3); porN = 1; idle(3);

    // R1 reset state
    check(alertN == 1'b1, "R1 alertN after reset", alertN, 1);
    check(killCnt == 0, "R1 no kill after reset", killCnt, 0);
    txStart();
    rd(0, 8'h00, "R1 status after reset");
    rd(1, 8'h00, "R1 ctrl after reset");
    rd(2, 8'h00, "R1 scratch after reset");
    txStop();

    // R2 normal access
    txStart();
    wr(1, 8'h06); wr(2, 8'hA5);
    rd(1, 8'h06, "R2 ctrl readback");
    rd(2, 8'hA5, "R2 scratch readback");
    rd(0, 8'h06, "R2 status flags");
    txStop();

    // R8 software reset mid-cycle: zero reads, dropped writes, flags kept
    txStart();
    swRst = 1; @(negedge clk); swRst = 0;
    check(alertN == 1'b0, "R8 alert after software reset", alertN, 0);
    rd(2, 8'h00, "R8 aborted read zero");
    wr(2, 8'h3C);
    rd(0, 8'h00, "R8 aborted status read zero");
    txStop();
    check(alertN == 1'b0, "R9 aborted status read keeps alert", alertN, 0);
    txStart();
    rd(2, 8'hA5, "R8 aborted write dropped");
    rd(0, 8'h07, "R8 init set, flags kept");
    check(alertN == 1'b1, "R9 alert released by status read", alertN, 1);
    rd(0, 8'h06, "R9 init cleared");
    txStop();

    // R11 selective reset while idle
    selRst = 1; @(negedge clk); selRst = 0;
    check(alertN == 1'b0, "R11 alert after idle selective reset", alertN, 0);
    txStart();
    wr(2, 8'h5A);
    rd(2, 8'h5A, "R11 next transaction not aborted");
    rd(0, 8'h07, "R11 status after idle selective reset");
    txStop();

    // R6/R7 D3 to D0 during a transaction
    pwrState = 2'd3; idle(3);
    txStart();
    pwrState = 2'd0; @(negedge clk);
    check(alertN == 1'b0, "R7 alert after D3 to D0", alertN, 0);
    rd(1, 8'h00, "R6 aborted read zero");
    wr(2, 8'h11);
    wr(1, 8'h06);
    rd(2, 8'h00, "R6 still aborted before STOP");
    txStop();
    txStart();
    rd(2, 8'h5A, "R6 write in aborted cycle dropped");
    rd(0, 8'h01, "R7 init set, flags cleared");
    txStop();

    // R3 alternate reset assertion kills, release does not
    txStart(); wr(1, 8'h06); rd(1, 8'h06, "R2 flags set before kill"); txStop();
    begin
      automatic int k0 = killCnt;
      txStart();
      altRstN = 0; idle(6);
      check(killCnt == k0 + 1, "R3 one kill on alt assert", killCnt, k0 + 1);
      altRstN = 1; idle(6);
      check(killCnt == k0 + 1, "R3 no kill on alt release", killCnt, k0 + 1);
      txStop();
      txStart(); rd(1, 8'h00, "R3 flags cleared by alt reset"); txStop();
      txStart(); wr(1, 8'h06); txStop();
      hardRstN = 0; idle(6);
      check(killCnt == k0 + 2, "R3 one kill on hard assert outside D3", killCnt, k0 + 2);
      hardRstN = 1; idle(6);
      check(killCnt == k0 + 2, "R3 no kill on hard release outside D3", killCnt, k0 + 2);
      txStart(); rd(1, 8'h00, "R3 flags cleared by hard reset"); txStop();
    end

    // R4 isolate acts on release only
    begin
      automatic int k0 = killCnt;
      txStart(); wr(1, 8'h06); txStop();
      isolateN = 0; idle(6);
      check(killCnt == k0, "R4 no kill on isolate assert", killCnt, k0);
      txStart(); rd(1, 8'h06, "R4 flags kept on isolate assert"); txStop();
      isolateN = 1; idle(6);
      check(killCnt == k0 + 1, "R4 kill on isolate release", killCnt, k0 + 1);
      txStart(); rd(1, 8'h00, "R4 flags cleared on isolate release"); txStop();
    end

    // R5 hard reset in D3 acts on release
    begin
      automatic int k0 = killCnt;
      pwrState = 2'd3; idle(3);
      hardRstN = 0; idle(6);
      check(killCnt == k0, "R5 no kill on hard assert in D3", killCnt, k0);
      hardRstN = 1; idle(6);
      check(killCnt == k0 + 1, "R5 kill on hard release in D3", killCnt, k0 + 1);
      pwrState = 2'd0; idle(2);
      txStart(); rd(0, 8'h01, "R7 init after D3 exit"); txStop();
    end

    // R10 hard and graceful in the same clock
    begin
      automatic int k0 = killCnt;
      txStart(); wr(1, 8'h06); txStop();
      check(alertN == 1'b1, "R10 alert idle before collision", alertN, 1);
      txStart();
      altRstN = 0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); swRst = 1;
      @(negedge clk); swRst = 0;
      idle(3);
      check(killCnt == k0 + 1, "R10 kill on collision", killCnt, k0 + 1);
      check(alertN == 1'b1, "R10 no alert on collision", alertN, 1);
      txStop();
      altRstN = 1; idle(6);
      txStart();
      wr(2, 8'h77);
      rd(2, 8'h77, "R10 no abort latched");
      rd(0, 8'h00, "R10 flags cleared, no init");
      txStop();
    end

    idle(4);
    check(expQ.size() == 0, "R2 all reads answered", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule